// File: doc/BRIEF.md
# Four-Level GPU Page Table Walker

This block turns GPU virtual addresses into physical addresses by walking a four-level translation table stored in memory. A client presents a context number and a 64-bit virtual address. The address carries 40 significant bits and is sign-extended above them. The walker first checks the sign extension. It then finds the per-context root table from a base input and reads one descriptor per level over a simple memory read port. It returns either a physical address or a fault with a cause code and the level at which the walk stopped.

Pages are 16 KB. The table tree is lopsided: the root has two entries, the next level has eight, and the last two levels have 2048 entries each. The root entry is selected by VA bit 39. Entry 0 holds a per-context user half. Entry 1 holds a kernel half, which all contexts may point at the same level-1 table. Context 0 carries only the kernel half. The block handles one translation at a time, and its result stays on the output until the client takes it.

Top module: `gpu_pt_walker`

## Requirements
- R1: When bits 63:40 of the request address differ from bit 39, the result is a fault with cause 1 (address size) at level 0, and no memory read is issued.
- R2: On success the result has fault = 0 and cause 0. Physical bits 13:0 equal VA bits 13:0, and physical bits 39:14 equal bits 39:14 of the level-3 descriptor.
- R3: The table index comes from VA bit 39 at level 0, bits 38:36 at level 1, bits 35:25 at level 2 and bits 24:14 at level 3. Each non-root entry is read at the table base plus index × 8, where the table base is bits 39:14 of the previous descriptor with 14 zero bits appended.
- R4: The first read of every walk is at root_base + context × 0x10 + VA[39] × 8.
- R5: A request from context 0 with VA bit 39 = 0 faults with cause 4 at level 0, and no memory read is issued.
- R6: A descriptor with bit 0 = 0 ends the walk with a fault of cause 2, and the level output gives the level (0 to 3) of that descriptor.
- R7: A valid descriptor with bit 1 = 0 ends the walk with a fault of cause 3 at that level, at level 3 as well as at levels 0 to 2.
- R8: A successful walk issues exactly four memory reads, one per level.
- R9: Only one read is outstanding at a time. After a read is accepted, no new read is requested until its response has arrived. While a read waits for mem_req_ready, its address is held.
- R10: Requests are taken only when req_ready is high. Once rsp_valid rises, the fault, cause, level and address outputs hold unchanged until rsp_ready is seen. No new request is accepted during that time.
- R11: Descriptor bits 63:40 and 13:2 have no effect on the walk or on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_ctx | input | 4 | Context number |
| req_va | input | 64 | Sign-extended virtual address |
| root_base | input | 40 | Physical base of the per-context root tables |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 40 | Physical address of the descriptor |
| mem_rsp_valid | input | 1 | Descriptor data returned |
| mem_rsp_data | input | 64 | Descriptor |
| rsp_valid | output | 1 | Translation result present |
| rsp_ready | input | 1 | Client takes the result |
| rsp_fault | output | 1 | Translation failed |
| rsp_cause | output | 3 | 0 ok, 1 address size, 2 invalid descriptor, 3 non-table descriptor, 4 user half in context 0 |
| rsp_level | output | 2 | Level at which the walk ended |
| rsp_pa | output | 40 | Physical address (valid when no fault) |

## Verification
The hardest cases to reach from the ports are faults deep in the tree. A fault at level 2 or 3 needs a tree that is valid down to the level above it and broken just at the entry the address selects. The bench builds the tree on demand in a behavioural memory and maps one anchor address. It then changes one index field at a time, so each derived address walks down the valid path and leaves it at exactly one level, at an entry that is either missing or lacks the table bit. A sweep over every context, both halves and the extreme index values covers the root placement and index extraction. The memory stalls handshakes and varies its latency, and one result is held back to exercise the hold rule.

// File: rtl/pt_walk_pkg.sv
// Shared types for the GPU page table walker.
// Assumes a fixed depth of four levels; widths come from module parameters.
package pt_walk_pkg;

    typedef enum logic [2:0] {
        CAUSE_NONE      = 3'd0,
        CAUSE_ADDR_SIZE = 3'd1,
        CAUSE_INVALID   = 3'd2,
        CAUSE_BLOCK     = 3'd3,
        CAUSE_CTX0_USER = 3'd4
    } pt_cause_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_DONE
    } pt_state_e;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pt_va_check.sv
// Checks that a wide input address is a proper sign extension of its
// VA_BITS-wide significant part, and reports which half it falls in.
// Assumes IN_BITS >= VA_BITS.
module pt_va_check #(
    parameter int IN_BITS = 64,
    parameter int VA_BITS = 40
) (
    input  logic [IN_BITS-1:0] va,
    output logic               sign_ok,
    output logic               upper_half
);
    // Top significant bit selects the half.
    assign upper_half = va[VA_BITS-1];

    generate
        if (IN_BITS > VA_BITS) begin : g_ext
            // All extension bits plus the top significant bit must agree.
            assign sign_ok = (&va[IN_BITS-1:VA_BITS-1]) | ~(|va[IN_BITS-1:VA_BITS-1]);
        end else begin : g_noext
            assign sign_ok = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/pt_index_sel.sv
// Extracts the table index for the current walk level from the virtual
// page number (VA without its page offset). Level 0 uses the top bits.
module pt_index_sel #(
    parameter int L0_BITS  = 1,
    parameter int L1_BITS  = 3,
    parameter int L2_BITS  = 11,
    parameter int L3_BITS  = 11,
    parameter int IDX_W    = 11,
    parameter int VPN_BITS = L0_BITS + L1_BITS + L2_BITS + L3_BITS
) (
    input  logic [VPN_BITS-1:0] vpn,
    input  logic [1:0]          level,
    output logic [IDX_W-1:0]    idx
);
    localparam int L2_LSB = L3_BITS;
    localparam int L1_LSB = L2_LSB + L2_BITS;
    localparam int L0_LSB = L1_LSB + L1_BITS;

    // Pick the field of the current level, zero-extended.
    always_comb begin
        case (level)
            2'd0:    idx = IDX_W'(vpn[L0_LSB +: L0_BITS]);
            2'd1:    idx = IDX_W'(vpn[L1_LSB +: L1_BITS]);
            2'd2:    idx = IDX_W'(vpn[L2_LSB +: L2_BITS]);
            default: idx = IDX_W'(vpn[0 +: L3_BITS]);
        endcase
    end
endmodule

// File: rtl/pt_desc_decode.sv
// Splits a table descriptor into valid bit, table bit and the page-aligned
// next-level base. Bits outside these fields are deliberately ignored.
module pt_desc_decode #(
    parameter int DESC_BITS = 64,
    parameter int PA_BITS   = 40,
    parameter int PAGE_BITS = 14
) (
    input  logic [DESC_BITS-1:0] desc,
    output logic                 d_valid,
    output logic                 d_table,
    output logic [PA_BITS-1:0]   d_base
);
    logic desc_unused;

    // Field extraction.
    assign d_valid     = desc[0];
    assign d_table     = desc[1];
    assign d_base      = {desc[PA_BITS-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
    assign desc_unused = ^{desc[DESC_BITS-1:PA_BITS], desc[PAGE_BITS-1:2]};
endmodule

// File: rtl/gpu_pt_walker.sv
// Four-level page table walker for 40-bit GPU virtual addresses.
// Takes one request at a time, issues one descriptor read per level and
// waits for each response before the next. Holds its result until taken.
// Assumes memory returns exactly one response per accepted read.
module gpu_pt_walker
    import pt_walk_pkg::*;
#(
    parameter int PA_BITS    = 40,
    parameter int PAGE_BITS  = 14,
    parameter int L0_BITS    = 1,
    parameter int L1_BITS    = 3,
    parameter int L2_BITS    = 11,
    parameter int L3_BITS    = 11,
    parameter int CTX_BITS   = 4,
    parameter int IN_VA_BITS = 64,
    parameter int DESC_BITS  = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [CTX_BITS-1:0]   req_ctx,
    input  logic [IN_VA_BITS-1:0] req_va,
    input  logic [PA_BITS-1:0]    root_base,
    output logic                  mem_req_valid,
    input  logic                  mem_req_ready,
    output logic [PA_BITS-1:0]    mem_req_addr,
    input  logic                  mem_rsp_valid,
    input  logic [DESC_BITS-1:0]  mem_rsp_data,
    output logic                  rsp_valid,
    input  logic                  rsp_ready,
    output logic                  rsp_fault,
    output logic [2:0]            rsp_cause,
    output logic [1:0]            rsp_level,
    output logic [PA_BITS-1:0]    rsp_pa
);
    localparam int VPN_BITS    = L0_BITS + L1_BITS + L2_BITS + L3_BITS;
    localparam int VA_BITS     = VPN_BITS + PAGE_BITS;
    localparam int IDX_W       = max_int(max_int(L0_BITS, L1_BITS), max_int(L2_BITS, L3_BITS));
    localparam int ENTRY_SHIFT = $clog2(DESC_BITS / 8);
    localparam int ROOT_SHIFT  = L0_BITS + ENTRY_SHIFT;
    localparam logic [1:0] LAST_LEVEL = 2'd3;

    pt_state_e            state_q;
    logic [CTX_BITS-1:0]  ctx_q;
    logic [VA_BITS-1:0]   va_q;
    logic [1:0]           level_q;
    logic [PA_BITS-1:0]   base_q;
    logic [PA_BITS-1:0]   pa_q;
    logic                 fault_q;
    pt_cause_e            cause_q;
    logic [2:0]           walk_reads;

    logic                 sign_ok, upper_half;
    logic [IDX_W-1:0]     idx;
    logic                 d_valid, d_table;
    logic [PA_BITS-1:0]   d_base;
    logic                 accept;

    pt_va_check #(.IN_BITS(IN_VA_BITS), .VA_BITS(VA_BITS)) u_va_check (
        .va(req_va), .sign_ok(sign_ok), .upper_half(upper_half)
    );

    pt_index_sel #(.L0_BITS(L0_BITS), .L1_BITS(L1_BITS), .L2_BITS(L2_BITS),
                   .L3_BITS(L3_BITS), .IDX_W(IDX_W), .VPN_BITS(VPN_BITS)) u_index_sel (
        .vpn(va_q[VA_BITS-1:PAGE_BITS]), .level(level_q), .idx(idx)
    );

    pt_desc_decode #(.DESC_BITS(DESC_BITS), .PA_BITS(PA_BITS), .PAGE_BITS(PAGE_BITS)) u_desc (
        .desc(mem_rsp_data), .d_valid(d_valid), .d_table(d_table), .d_base(d_base)
    );

    // Handshake-facing outputs derived from the walk state.
    assign req_ready     = (state_q == ST_IDLE);
    assign accept        = req_valid && req_ready;
    assign mem_req_valid = (state_q == ST_REQ);
    assign rsp_valid     = (state_q == ST_DONE);
    assign rsp_fault     = fault_q;
    assign rsp_cause     = cause_q;
    assign rsp_level     = level_q;
    assign rsp_pa        = pa_q;

    // Descriptor address: root slot for level 0, table entry otherwise.
    always_comb begin
        if (level_q == 2'd0)
            mem_req_addr = root_base + (PA_BITS'(ctx_q) << ROOT_SHIFT)
                         + (PA_BITS'(idx) << ENTRY_SHIFT);
        else
            mem_req_addr = base_q + (PA_BITS'(idx) << ENTRY_SHIFT);
    end

    // Walk state machine and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ctx_q   <= '0;
            va_q    <= '0;
            level_q <= 2'd0;
            base_q  <= '0;
            pa_q    <= '0;
            fault_q <= 1'b0;
            cause_q <= CAUSE_NONE;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        ctx_q   <= req_ctx;
                        va_q    <= req_va[VA_BITS-1:0];
                        level_q <= 2'd0;
                        pa_q    <= '0;
                        if (!sign_ok) begin
                            fault_q <= 1'b1;
                            cause_q <= CAUSE_ADDR_SIZE;
                            state_q <= ST_DONE;
                        end else if (req_ctx == '0 && !upper_half) begin
                            fault_q <= 1'b1;
                            cause_q <= CAUSE_CTX0_USER;
                            state_q <= ST_DONE;
                        end else begin
                            fault_q <= 1'b0;
                            cause_q <= CAUSE_NONE;
                            state_q <= ST_REQ;
                        end
                    end
                end
                ST_REQ: begin
                    if (mem_req_ready) state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (!d_valid) begin
                            fault_q <= 1'b1;
                            cause_q <= CAUSE_INVALID;
                            state_q <= ST_DONE;
                        end else if (!d_table) begin
                            fault_q <= 1'b1;
                            cause_q <= CAUSE_BLOCK;
                            state_q <= ST_DONE;
                        end else if (level_q == LAST_LEVEL) begin
                            pa_q    <= {d_base[PA_BITS-1:PAGE_BITS], va_q[PAGE_BITS-1:0]};
                            state_q <= ST_DONE;
                        end else begin
                            base_q  <= d_base;
                            level_q <= level_q + 2'd1;
                            state_q <= ST_REQ;
                        end
                    end
                end
                default: begin
                    if (rsp_ready) state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Count reads accepted in the current walk (used by the checks below).
    always_ff @(posedge clk) begin
        if (!rst_n)
            walk_reads <= '0;
        else if (accept)
            walk_reads <= '0;
        else if (mem_req_valid && mem_req_ready)
            walk_reads <= walk_reads + 3'd1;
    end

    p_addr_size_fault_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !sign_ok) |=> (rsp_valid && rsp_cause == CAUSE_ADDR_SIZE && walk_reads == 3'd0));

    p_ctx0_user_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && sign_ok && req_ctx == '0 && !upper_half) |=>
        (rsp_valid && rsp_cause == CAUSE_CTX0_USER && walk_reads == 3'd0));

    p_invalid_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_cause == CAUSE_INVALID) |-> (walk_reads == {1'b0, rsp_level} + 3'd1));

    p_block_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_cause == CAUSE_BLOCK) |-> (walk_reads == {1'b0, rsp_level} + 3'd1));

    p_four_reads_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (walk_reads == 3'd4));

    p_one_outstanding_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

    p_addr_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    p_result_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pa) && $stable(rsp_cause)
                                       && $stable(rsp_fault) && $stable(rsp_level)));

    p_no_accept_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);
endmodule

// File: tb/gpu_pt_walker_bench.sv
// Self-checking bench: builds tables in a behavioural memory on demand and
// sweeps contexts, halves and index extremes; computes results arithmetically.
module gpu_pt_walker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_ctx = '0;
    logic [63:0] req_va = '0;
    logic [39:0] root_base = 40'h00_0010_0000;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [39:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic        rsp_fault;
    logic [2:0]  rsp_cause;
    logic [1:0]  rsp_level;
    logic [39:0] rsp_pa;

    int checks = 0;
    int errors = 0;
    int overlap_errs = 0;
    int n_reads = 0;
    logic [39:0] addr_log [4];
    logic [63:0] mem [logic [39:0]];
    logic [39:0] next_tab = 40'h00_0100_0000;

    logic        r_fault;
    logic [2:0]  r_cause;
    logic [1:0]  r_level;
    logic [39:0] r_pa;

    gpu_pt_walker u_gpu_pt_walker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_ctx(req_ctx), .req_va(req_va), .root_base(root_base),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_fault(rsp_fault), .rsp_cause(rsp_cause), .rsp_level(rsp_level),
        .rsp_pa(rsp_pa)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    function automatic logic [63:0] rd(input logic [39:0] a);
        return mem.exists(a) ? mem[a] : 64'h0;
    endfunction

    // Descriptor with junk in the ignored bits (R11).
    function automatic logic [63:0] mk_desc(input logic [39:0] pa);
        return 64'hABCD_EF00_0000_0000 | {24'h0, pa & 40'hFF_FFFF_C000} | 64'h2AB4 | 64'h3;
    endfunction

    function automatic logic [39:0] tab_of(input logic [63:0] d);
        return {d[39:14], 14'h0};
    endfunction

    // Make sure entry a holds a table pointer; allocate one if missing.
    task automatic ensure(input logic [39:0] a);
        if (!mem.exists(a)) begin
            mem[a] = mk_desc(next_tab);
            next_tab = next_tab + 40'h4000;
        end
    endtask

    function automatic logic [39:0] root_addr(input logic [3:0] c, input logic [63:0] va);
        return root_base + {36'h0, c} * 40'h10 + (va[39] ? 40'h8 : 40'h0);
    endfunction

    // Map va in context c to physical page pg, creating tables as needed.
    task automatic map(input logic [3:0] c, input logic [63:0] va, input logic [39:0] pg);
        logic [39:0] a;
        a = root_addr(c, va);                       ensure(a);
        a = tab_of(mem[a]) + {37'h0, va[38:36]} * 8; ensure(a);
        a = tab_of(mem[a]) + {29'h0, va[35:25]} * 8; ensure(a);
        a = tab_of(mem[a]) + {29'h0, va[24:14]} * 8;
        mem[a] = mk_desc(pg);
    endtask

    // Behavioural memory: stalls handshakes, varies latency, one read at a time.
    initial begin
        int wait_cnt;
        bit stall;
        logic [39:0] a_q;
        wait_cnt = 0;
        stall = 1'b0;
        a_q = '0;
        forever begin
            @(negedge clk);
            mem_req_ready = 1'b0;
            mem_rsp_valid = 1'b0;
            if (wait_cnt > 0) begin
                if (mem_req_valid) overlap_errs++;
                wait_cnt--;
                if (wait_cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data = rd(a_q);
                end
            end else if (mem_req_valid && rst_n) begin
                stall = ~stall;
                if (!stall) begin
                    mem_req_ready = 1'b1;
                    a_q = mem_req_addr;
                    if (n_reads < 4) addr_log[n_reads] = mem_req_addr;
                    n_reads++;
                    wait_cnt = 1 + (n_reads % 3);
                end
            end
        end
    end

    // One translation; hold > 0 delays acceptance of the result.
    task automatic xlate(input logic [3:0] c, input logic [63:0] va, input int hold);
        int t;
        @(negedge clk);
        n_reads = 0;
        req_valid = 1'b1;
        req_ctx = c;
        req_va = va;
        @(negedge clk);
        req_valid = 1'b0;
        t = 0;
        while (!rsp_valid && t < 500) begin
            @(negedge clk);
            t++;
        end
        chk(rsp_valid, "R10", "result arrives", {63'h0, rsp_valid}, 64'h1);
        r_fault = rsp_fault;
        r_cause = rsp_cause;
        r_level = rsp_level;
        r_pa = rsp_pa;
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(rsp_valid && rsp_pa == r_pa && rsp_cause == r_cause && rsp_level == r_level
                && rsp_fault == r_fault, "R10", "result held", {24'h0, rsp_pa}, {24'h0, r_pa});
            chk(!req_ready, "R10", "no accept while holding", {63'h0, req_ready}, 64'h0);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
    endtask

    // Successful walk: PA, read count and every read address.
    task automatic expect_hit(input logic [3:0] c, input logic [63:0] va, input logic [39:0] pg,
                              input int hold);
        logic [39:0] e0, e1, e2, e3;
        e0 = root_addr(c, va);
        e1 = tab_of(rd(e0)) + {37'h0, va[38:36]} * 8;
        e2 = tab_of(rd(e1)) + {29'h0, va[35:25]} * 8;
        e3 = tab_of(rd(e2)) + {29'h0, va[24:14]} * 8;
        xlate(c, va, hold);
        chk(!r_fault && r_cause == 3'd0, "R2", "no fault", {61'h0, r_cause}, 64'h0);
        chk(r_pa == {pg[39:14], va[13:0]}, "R2 R11", "physical address", {24'h0, r_pa},
            {24'h0, pg[39:14], va[13:0]});
        chk(n_reads == 4, "R8", "read count", 64'(n_reads), 64'd4);
        chk(addr_log[0] == e0, "R4", "root entry address", {24'h0, addr_log[0]}, {24'h0, e0});
        chk(addr_log[1] == e1 && addr_log[2] == e2 && addr_log[3] == e3, "R3",
            "level entry addresses", {24'h0, addr_log[3]}, {24'h0, e3});
    endtask

    task automatic expect_fault(input logic [3:0] c, input logic [63:0] va, input logic [2:0] cause,
                                input logic [1:0] lvl, input int reads, input string rq);
        xlate(c, va, 0);
        chk(r_fault && r_cause == cause, rq, "fault cause", {61'h0, r_cause}, {61'h0, cause});
        chk(r_level == lvl, rq, "fault level", {62'h0, r_level}, {62'h0, lvl});
        chk(n_reads == reads, rq, "reads before fault", 64'(n_reads), 64'(reads));
    endtask

    function automatic logic [63:0] mk_va(input bit kern, input logic [2:0] i1, input logic [10:0] i2,
                                          input logic [10:0] i3, input logic [13:0] off);
        return {{25{kern}}, i1, i2, i3, off};
    endfunction

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] va, anchor;
        logic [39:0] a, t2, t3;
        repeat (3) @(negedge clk);
        chk(req_ready && !rsp_valid && !mem_req_valid, "R10", "reset state",
            {61'h0, req_ready, rsp_valid, mem_req_valid}, 64'h4);
        rst_n = 1'b1;
        @(negedge clk);

        // Shared kernel level-1 table in every context (R4).
        a = next_tab;
        next_tab = next_tab + 40'h4000;
        for (int c = 0; c < 16; c++) mem[root_base + 40'(c) * 40'h10 + 40'h8] = mk_desc(a);

        // User half, contexts 1..14, three index patterns each (R2, R3, R4, R8).
        for (int c = 1; c < 15; c++) begin
            for (int k = 0; k < 3; k++) begin
                logic [10:0] i2, i3;
                logic [39:0] pg;
                i2 = (k == 0) ? 11'd0 : (k == 1) ? 11'd2047 : 11'(c * 37);
                i3 = (k == 0) ? 11'(c * 91) : (k == 1) ? 11'd0 : 11'd2047;
                pg = 40'(c * 3 + k + 1) * 40'h13_5790_0000 & 40'hFF_FFFF_C000;
                va = mk_va(1'b0, 3'(c + k), i2, i3, (k == 0) ? 14'h0 : (k == 1) ? 14'h3FFF : 14'(c * 313));
                map(4'(c), va, pg);
                expect_hit(4'(c), va, pg, (c == 5 && k == 1) ? 3 : 0);
            end
        end

        // Kernel half, built once, translated from cycling contexts incl. 0.
        for (int i = 0; i < 8; i++) begin
            for (int k = 0; k < 3; k++) begin
                logic [10:0] i2;
                logic [39:0] pg;
                i2 = (k == 0) ? 11'd0 : (k == 1) ? 11'd2047 : 11'd683;
                pg = 40'hF0_0000_0000 - 40'(i * 3 + k) * 40'h4000;
                va = mk_va(1'b1, 3'(i), i2, 11'(i * 257 + k), 14'(i * 1111 + k));
                map(4'd0, va, pg);
                expect_hit(4'((i * 3 + k) % 16), va, pg, 0);
            end
        end

        // Sign-extension faults (R1).
        expect_fault(4'd3, 64'h0000_0100_0000_0000, 3'd1, 2'd0, 0, "R1");
        expect_fault(4'd3, 64'hFFFF_FF7F_FFFF_FFFF, 3'd1, 2'd0, 0, "R1");
        expect_fault(4'd0, 64'h8000_0080_0000_0000, 3'd1, 2'd0, 0, "R1");

        // Context 0 user half (R5).
        expect_fault(4'd0, mk_va(1'b0, 3'd1, 11'd5, 11'd6, 14'h10), 3'd4, 2'd0, 0, "R5");

        // Faults at each level, context 15 (R6, R7).
        anchor = mk_va(1'b0, 3'd2, 11'd100, 11'd200, 14'h123);
        expect_fault(4'd15, anchor, 3'd2, 2'd0, 1, "R6");
        map(4'd15, anchor, 40'h12_3456_C000);
        expect_hit(4'd15, anchor, 40'h12_3456_C000, 0);
        expect_fault(4'd15, mk_va(1'b0, 3'd3, 11'd100, 11'd200, 14'h0), 3'd2, 2'd1, 2, "R6");
        expect_fault(4'd15, mk_va(1'b0, 3'd2, 11'd101, 11'd200, 14'h0), 3'd2, 2'd2, 3, "R6");
        expect_fault(4'd15, mk_va(1'b0, 3'd2, 11'd100, 11'd201, 14'h0), 3'd2, 2'd3, 4, "R6");

        a  = tab_of(rd(root_addr(4'd15, anchor)));
        mem[a + 40'd5 * 8] = mk_desc(40'h1_0000_0000) & ~64'h2;
        expect_fault(4'd15, mk_va(1'b0, 3'd5, 11'd0, 11'd0, 14'h0), 3'd3, 2'd1, 2, "R7");
        t2 = tab_of(rd(a + 40'd2 * 8));
        mem[t2 + 40'd102 * 8] = mk_desc(40'h2_0000_0000) & ~64'h2;
        expect_fault(4'd15, mk_va(1'b0, 3'd2, 11'd102, 11'd0, 14'h0), 3'd3, 2'd2, 3, "R7");
        t3 = tab_of(rd(t2 + 40'd100 * 8));
        mem[t3 + 40'd202 * 8] = mk_desc(40'h3_0000_0000) & ~64'h2;
        expect_fault(4'd15, mk_va(1'b0, 3'd2, 11'd100, 11'd202, 14'h0), 3'd3, 2'd3, 4, "R7");

        chk(overlap_errs == 0, "R9", "no read while one is outstanding", 64'(overlap_errs), 64'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule